// File: doc/BRIEF.md
# Asynchronous SRAM Interface Controller

This block lets a clocked host read and write an external asynchronous static RAM. The RAM has a 19-bit word address and a 16-bit data bus, split into two byte lanes. The controller sequences the active-low chip select, write enable, output enable and per-lane byte enables. It also drives the write data through a separate output-enable for the pad tri-state. Every phase length comes from minimum and maximum timing figures given in nanoseconds. Each figure is turned into a whole number of clock cycles using the clock period parameter.

The host offers a request as a valid/ready stream: `host_valid` with write flag, address, write data and a 2-bit lane mask. The controller takes one request at a time. `host_ready` is high only while the controller is idle, so back-pressure lasts for the whole of a memory transaction. A request is taken on the edge where `host_valid` and `host_ready` are both high. Completion is a single-cycle `rsp_valid` pulse that carries the read data. This response has no back-pressure, so the host must take it in the cycle it appears. Between transactions the memory is deselected with all strobes high and the bus released.

Top module: `sram_async_ctrl`

## Requirements
- R1: After reset, and whenever `host_ready` is high, all of the following hold: chip select, write enable, output enable and both byte enables are high; `mem_dq_oe` is low; `rsp_valid` is low.
- R2: A request is accepted on a clock edge with `host_valid` and `host_ready` both high. `host_ready` stays low until the response. `rsp_valid` is high for exactly one cycle, and `host_ready` is high in the cycle after it.
- R3: A read holds chip select low, output enable low and write enable high. The bus is captured on the last cycle of that phase and returned on `rsp_rdata` with `rsp_valid`.
- R4: Mask bit 0 selects the lower lane (data bits 7:0, `mem_be_n[0]`) and mask bit 1 selects the upper lane (bits 15:8, `mem_be_n[1]`). In a read response, lanes not selected read as zero.
- R5: A write asserts write enable low only while chip select is low, output enable is high and the data bus is driven. The memory sees a strobe long enough for the stored word to be updated.
- R6: During any strobed transaction, `mem_be_n` equals the bitwise inverse of the accepted mask for every cycle chip select is low. Only the selected lanes of a word are written.
- R7: `mem_dq_oe` is never high while output enable is low. A write that follows a read drives the bus only after at least ceil(T_OHZ_NS/CLK_NS) cycles have passed since output enable rose.
- R8: A request with mask 2'b00 completes with `rsp_valid` in the cycle after acceptance. No strobe is asserted, the memory is left unchanged, and `rsp_rdata` reads zero.
- R9: Phase lengths follow the rules below, where c(t) = max(1, ceil(t/CLK_NS)).
  - Read: output enable is low for max(c(tRC), c(tAA), c(tOE)) cycles, which is 18 at the default parameters.
  - Write: write enable is low for max(c(tWP), c(tDW), c(tAW)-c(tAS), c(tCW)-c(tAS), c(tWC)-c(tAS)-max(c(tWR),c(tDH))) cycles, which is 16 at the default parameters.
- R10: `mem_addr` is stable in every cycle that chip select stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_valid | input | 1 | Request offered |
| host_ready | output | 1 | Controller idle, request can be taken |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | 19 | Word address |
| host_wdata | input | 16 | Write data |
| host_mask | input | 2 | Lane select, bit 0 lower, bit 1 upper |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 16 | Read data, unselected lanes zero |
| mem_addr | output | 19 | Memory address |
| mem_dq_o | output | 16 | Data toward memory |
| mem_dq_oe | output | 1 | Pad drive enable for `mem_dq_o` |
| mem_dq_i | input | 16 | Data from memory |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_be_n | output | 2 | Byte enables, active low, bit 0 lower lane |

## Verification
Some internal faults show up as timing errors at the pins. A wrong phase counter or state path makes output enable or write enable low for the wrong number of cycles within the same transaction. If the capture edge is off, the read data carries lanes that the memory model has not yet made valid, and the error shows in the very next response. A stale turnaround flag puts `mem_dq_oe` high too soon after output enable rises. A wrong latched mask gives byte enables that do not match the request in the first strobed cycle, or shows up as a corrupted lane on the next read-back.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_TURN,
    ST_RD,
    ST_WSU,
    ST_WPUL,
    ST_WREC,
    ST_RESP
  } ctrl_st_e;

  // Ceiling conversion of a time in ns to cycles, never below one cycle.
  function automatic int unsigned ns2cyc(input int unsigned ns, input int unsigned clk_ns);
    int unsigned c;
    c = (ns + clk_ns - 1) / clk_ns;
    return (c == 0) ? 1 : c;
  endfunction

  function automatic int unsigned umax(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

  function automatic int unsigned usub(input int unsigned a, input int unsigned b);
    return (a > b) ? a - b : 0;
  endfunction

endpackage

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
  parameter int unsigned CW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] len,
  output logic          last
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt_q <= '0;
    else if (load)       cnt_q <= len;
    else if (cnt_q > 1)  cnt_q <= cnt_q - 1'b1;
  end

  assign last = (cnt_q == CW'(1));
endmodule

// File: rtl/sram_byte_lane.sv
module sram_byte_lane #(
  parameter int unsigned LW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          strobe_nxt,
  input  logic          sel_nxt,
  input  logic          cap,
  input  logic          cap_sel,
  input  logic [LW-1:0] din,
  output logic          be_n,
  output logic [LW-1:0] rd
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      be_n <= 1'b1;
      rd   <= '0;
    end else begin
      be_n <= !(strobe_nxt && sel_nxt);
      if (cap) rd <= cap_sel ? din : '0;
    end
  end
endmodule

// File: rtl/sram_async_ctrl.sv
module sram_async_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned AW       = 19,
  parameter int unsigned DW       = 16,
  parameter int unsigned CLK_NS   = 4,
  parameter int unsigned T_RC_NS  = 70,
  parameter int unsigned T_AA_NS  = 70,
  parameter int unsigned T_OE_NS  = 35,
  parameter int unsigned T_WC_NS  = 70,
  parameter int unsigned T_CW_NS  = 60,
  parameter int unsigned T_AW_NS  = 60,
  parameter int unsigned T_WP_NS  = 50,
  parameter int unsigned T_DW_NS  = 30,
  parameter int unsigned T_AS_NS  = 0,
  parameter int unsigned T_WR_NS  = 0,
  parameter int unsigned T_DH_NS  = 0,
  parameter int unsigned T_OHZ_NS = 20
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            host_valid,
  output logic            host_ready,
  input  logic            host_we,
  input  logic [AW-1:0]   host_addr,
  input  logic [DW-1:0]   host_wdata,
  input  logic [DW/8-1:0] host_mask,
  output logic            rsp_valid,
  output logic [DW-1:0]   rsp_rdata,
  output logic [AW-1:0]   mem_addr,
  output logic [DW-1:0]   mem_dq_o,
  output logic            mem_dq_oe,
  input  logic [DW-1:0]   mem_dq_i,
  output logic            mem_cs_n,
  output logic            mem_we_n,
  output logic            mem_oe_n,
  output logic [DW/8-1:0] mem_be_n
);
  localparam int unsigned NL      = DW / 8;
  localparam int unsigned RD_CYC  = umax(umax(ns2cyc(T_RC_NS, CLK_NS), ns2cyc(T_AA_NS, CLK_NS)),
                                         ns2cyc(T_OE_NS, CLK_NS));
  localparam int unsigned SU_CYC  = ns2cyc(T_AS_NS, CLK_NS);
  localparam int unsigned REC_CYC = umax(ns2cyc(T_WR_NS, CLK_NS), ns2cyc(T_DH_NS, CLK_NS));
  localparam int unsigned WP_CYC  = umax(umax(ns2cyc(T_WP_NS, CLK_NS), ns2cyc(T_DW_NS, CLK_NS)),
                                    umax(umax(usub(ns2cyc(T_AW_NS, CLK_NS), SU_CYC),
                                              usub(ns2cyc(T_CW_NS, CLK_NS), SU_CYC)),
                                         usub(ns2cyc(T_WC_NS, CLK_NS), SU_CYC + REC_CYC)));
  localparam int unsigned FLT_CYC = ns2cyc(T_OHZ_NS, CLK_NS);
  localparam int unsigned MAX_CYC = umax(umax(RD_CYC, WP_CYC), umax(umax(SU_CYC, REC_CYC), FLT_CYC));
  localparam int unsigned CW      = $clog2(MAX_CYC + 1);

  ctrl_st_e         st_q, st_d;
  logic             accept, last, load, zero_mask;
  logic             prev_rd_q, strobe_nxt, cap;
  logic [NL-1:0]    mask_q, mask_nxt;
  logic [CW-1:0]    len;

  assign host_ready = (st_q == ST_IDLE);
  assign rsp_valid  = (st_q == ST_RESP);
  assign accept     = host_valid && host_ready;
  assign zero_mask  = (host_mask == '0);

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE: if (accept) begin
        if (zero_mask)    st_d = ST_RESP;
        else if (!host_we) st_d = ST_RD;
        else              st_d = prev_rd_q ? ST_TURN : ST_WSU;
      end
      ST_TURN: if (last) st_d = ST_WSU;
      ST_RD:   if (last) st_d = ST_RESP;
      ST_WSU:  if (last) st_d = ST_WPUL;
      ST_WPUL: if (last) st_d = ST_WREC;
      ST_WREC: if (last) st_d = ST_RESP;
      default: st_d = ST_IDLE;
    endcase
  end

  always_comb begin
    unique case (st_d)
      ST_TURN: len = CW'(FLT_CYC);
      ST_RD:   len = CW'(RD_CYC);
      ST_WSU:  len = CW'(SU_CYC);
      ST_WPUL: len = CW'(WP_CYC);
      ST_WREC: len = CW'(REC_CYC);
      default: len = CW'(1);
    endcase
  end
  assign load = (st_d != st_q);

  sram_phase_timer #(.CW(CW)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(load), .len(len), .last(last)
  );

  assign strobe_nxt = (st_d == ST_RD) || (st_d == ST_WSU) || (st_d == ST_WPUL) || (st_d == ST_WREC);
  assign mask_nxt   = accept ? host_mask : mask_q;
  assign cap        = ((st_q == ST_RD) && last) || (accept && zero_mask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= ST_IDLE;
      mask_q    <= '0;
      prev_rd_q <= 1'b0;
      mem_addr  <= '0;
      mem_dq_o  <= '0;
      mem_cs_n  <= 1'b1;
      mem_we_n  <= 1'b1;
      mem_oe_n  <= 1'b1;
      mem_dq_oe <= 1'b0;
    end else begin
      st_q      <= st_d;
      mask_q    <= mask_nxt;
      if (accept) begin
        mem_addr <= host_addr;
        mem_dq_o <= host_wdata;
      end
      if ((st_q == ST_RD) && last) prev_rd_q <= 1'b1;
      else if (st_d == ST_WSU)     prev_rd_q <= 1'b0;
      mem_cs_n  <= !strobe_nxt;
      mem_we_n  <= !(st_d == ST_WPUL);
      mem_oe_n  <= !(st_d == ST_RD);
      mem_dq_oe <= (st_d == ST_WSU) || (st_d == ST_WPUL) || (st_d == ST_WREC);
    end
  end

  for (genvar i = 0; i < NL; i++) begin : g_lane
    sram_byte_lane #(.LW(8)) u_lane (
      .clk(clk), .rst_n(rst_n),
      .strobe_nxt(strobe_nxt), .sel_nxt(mask_nxt[i]),
      .cap(cap), .cap_sel((st_q == ST_RD) && mask_q[i]),
      .din(mem_dq_i[i*8 +: 8]),
      .be_n(mem_be_n[i]), .rd(rsp_rdata[i*8 +: 8])
    );
  end
endmodule

// File: rtl/sram_async_ctrl_chk.sv
module sram_async_ctrl_chk #(
  parameter int unsigned AW      = 19,
  parameter int unsigned NL      = 2,
  parameter int unsigned FLT_CYC = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          host_ready,
  input logic          rsp_valid,
  input logic          mem_cs_n,
  input logic          mem_we_n,
  input logic          mem_oe_n,
  input logic          mem_dq_oe,
  input logic [NL-1:0] mem_be_n,
  input logic [AW-1:0] mem_addr
);
  int unsigned since_oe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  since_oe <= FLT_CYC;
    else if (!mem_oe_n)          since_oe <= 0;
    else if (since_oe < FLT_CYC) since_oe <= since_oe + 1;
  end

  // R1
  idle_deselect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    host_ready |-> (mem_cs_n && mem_we_n && mem_oe_n && !mem_dq_oe && (&mem_be_n) && !rsp_valid));
  // R2
  rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> (!rsp_valid && host_ready));
  // R5
  we_in_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> (!mem_cs_n && mem_oe_n && mem_dq_oe));
  // R7
  no_contention_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n |-> !mem_dq_oe);
  // R7
  float_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_dq_oe) |-> (since_oe >= FLT_CYC));
  // R8
  lane_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_cs_n |-> !(&mem_be_n));
  // R10
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_cs_n && $past(!mem_cs_n)) |-> $stable(mem_addr));
endmodule

bind sram_async_ctrl sram_async_ctrl_chk #(.AW(AW), .NL(NL), .FLT_CYC(FLT_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .host_ready(host_ready), .rsp_valid(rsp_valid),
  .mem_cs_n(mem_cs_n), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
  .mem_dq_oe(mem_dq_oe), .mem_be_n(mem_be_n), .mem_addr(mem_addr)
);

// File: tb/tb_sram_async_ctrl.sv
`timescale 1ns/1ps
module tb_sram_async_ctrl;
  localparam int CLK = 4;
  localparam int T_AA = 70, T_WP = 50, T_AW = 60, T_OHZ = 20;
  localparam int RD_EXP = (70 + CLK - 1) / CLK;           // max(c(70),c(70),c(35)) = 18
  localparam int WP_EXP = (70 + CLK - 1) / CLK - 1 - 1;    // c(tWC)-setup-recovery = 16 dominates 13,14,8
  localparam int NV = 12;
  // {we, addr, wdata, mask, expected read data}
  localparam logic [53:0] VECS [NV] = '{
    {1'b1, 19'h00010, 16'h1234, 2'b11, 16'h0000},
    {1'b0, 19'h00010, 16'h0000, 2'b11, 16'h1234},
    {1'b1, 19'h00010, 16'hABCD, 2'b01, 16'h0000},
    {1'b0, 19'h00010, 16'h0000, 2'b11, 16'h12CD},
    {1'b1, 19'h00010, 16'h5678, 2'b10, 16'h0000},
    {1'b0, 19'h00010, 16'h0000, 2'b10, 16'h5600},
    {1'b0, 19'h00010, 16'h0000, 2'b01, 16'h00CD},
    {1'b1, 19'h7FFFF, 16'hFFFF, 2'b11, 16'h0000},
    {1'b0, 19'h7FFFF, 16'h0000, 2'b11, 16'hFFFF},
    {1'b1, 19'h00010, 16'h0000, 2'b00, 16'h0000},
    {1'b0, 19'h00010, 16'h0000, 2'b11, 16'h56CD},
    {1'b0, 19'h00010, 16'h0000, 2'b00, 16'h0000}
  };

  logic clk = 0, rst_n = 0;
  logic host_valid = 0, host_we = 0;
  logic [18:0] host_addr = '0;
  logic [15:0] host_wdata = '0;
  logic [1:0]  host_mask = '0;
  logic host_ready, rsp_valid, mem_dq_oe, mem_cs_n, mem_we_n, mem_oe_n;
  logic [15:0] rsp_rdata, mem_dq_o, dq_model = 16'hA5A5;
  logic [18:0] mem_addr;
  logic [1:0]  mem_be_n;
  int checks = 0, failures = 0;
  int err_wr = 0, err_cont = 0, err_addr = 0;

  always #2 clk = ~clk;

  sram_async_ctrl dut (
    .clk(clk), .rst_n(rst_n), .host_valid(host_valid), .host_ready(host_ready),
    .host_we(host_we), .host_addr(host_addr), .host_wdata(host_wdata), .host_mask(host_mask),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .mem_addr(mem_addr), .mem_dq_o(mem_dq_o),
    .mem_dq_oe(mem_dq_oe), .mem_dq_i(dq_model), .mem_cs_n(mem_cs_n), .mem_we_n(mem_we_n),
    .mem_oe_n(mem_oe_n), .mem_be_n(mem_be_n)
  );

  // Memory model, evaluated between clock edges.
  logic [15:0] sram [logic [18:0]];
  int rd_cnt = 0, fl_cnt = 100, we_cnt = 0, cs_cnt = 0;
  logic prev_we_low = 0, prev_cs_low = 0, prev_drv = 0, drv_gap = 0;
  logic [18:0] prev_addr = '0;

  always @(negedge clk) begin
    logic rd_act;
    logic [15:0] word;
    rd_act = !mem_cs_n && !mem_oe_n && mem_we_n;
    rd_cnt = rd_act ? rd_cnt + 1 : 0;
    word = sram.exists(mem_addr) ? sram[mem_addr] : 16'h0000;
    for (int l = 0; l < 2; l++)
      dq_model[l*8 +: 8] = (rd_act && !mem_be_n[l] && (rd_cnt * CLK - CLK / 2 >= T_AA))
                           ? word[l*8 +: 8] : 8'hA5;
    fl_cnt = mem_oe_n ? fl_cnt + 1 : 0;
    if (mem_dq_oe && !mem_oe_n) err_cont++;
    if (mem_dq_oe && !prev_drv && ((fl_cnt - 1) * CLK < T_OHZ)) err_cont++;
    cs_cnt = mem_cs_n ? 0 : cs_cnt + 1;
    if (!mem_cs_n && !mem_we_n) begin
      we_cnt++;
      if (!mem_dq_oe) drv_gap = 1;
    end
    if (mem_we_n && prev_we_low) begin
      if (we_cnt * CLK >= T_WP && (cs_cnt - 1) * CLK >= T_AW && !drv_gap && !mem_cs_n) begin
        for (int l = 0; l < 2; l++)
          if (!mem_be_n[l]) word[l*8 +: 8] = mem_dq_o[l*8 +: 8];
        sram[mem_addr] = word;
      end else err_wr++;
      we_cnt = 0;
      drv_gap = 0;
    end
    if (!mem_cs_n && prev_cs_low && mem_addr != prev_addr) err_addr++;
    prev_we_low = !mem_we_n;
    prev_cs_low = !mem_cs_n;
    prev_addr   = mem_addr;
    prev_drv    = mem_dq_oe;
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic run_txn(input logic we, input logic [18:0] a, input logic [15:0] wd,
                         input logic [1:0] m, input logic [15:0] exp);
    int cs_lo = 0, oe_lo = 0, we_lo = 0, guard = 0;
    bit be_bad = 0, rdy_bad = 0;
    @(negedge clk);
    host_valid = 1; host_we = we; host_addr = a; host_wdata = wd; host_mask = m;
    while (!host_ready) @(negedge clk);
    @(negedge clk);
    host_valid = 0;
    while (!rsp_valid && guard < 1000) begin
      if (!mem_cs_n) begin
        cs_lo++;
        if (mem_be_n != ~m) be_bad = 1;
      end
      if (!mem_oe_n) oe_lo++;
      if (!mem_we_n) we_lo++;
      if (host_ready) rdy_bad = 1;
      guard++;
      @(negedge clk);
    end
    chk(rsp_valid && !rdy_bad, "R2", {31'd0, rdy_bad}, 0);
    if (m == 2'b00) begin
      chk(cs_lo == 0 && guard == 0, "R8", cs_lo, 0);
      if (!we) chk(rsp_rdata == 16'h0, "R8", rsp_rdata, 0);
    end else begin
      chk(!be_bad, "R6", {30'd0, m}, {30'd0, m});
      if (we) chk(we_lo == WP_EXP && oe_lo == 0, "R5", we_lo, WP_EXP);
      else begin
        chk(oe_lo == RD_EXP && we_lo == 0, "R9", oe_lo, RD_EXP);
        chk(rsp_rdata == exp, (m == 2'b11) ? "R3" : "R4", rsp_rdata, exp);
      end
    end
    @(negedge clk);
    chk(!rsp_valid && host_ready, "R2", {30'd0, rsp_valid, host_ready}, 1);
  endtask

  task automatic chk_idle(input string req);
    chk(mem_cs_n && mem_we_n && mem_oe_n && mem_be_n == 2'b11 && !mem_dq_oe && host_ready && !rsp_valid,
        req, {26'd0, mem_cs_n, mem_we_n, mem_oe_n, mem_be_n, mem_dq_oe}, 32'h3E);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk_idle("R1");                       // in reset
    rst_n = 1;
    @(negedge clk);
    chk_idle("R1");                       // after reset
    for (int i = 0; i < NV; i++)
      run_txn(VECS[i][53], VECS[i][52:34], VECS[i][33:18], VECS[i][17:16], VECS[i][15:0]);
    // R1: reset in the middle of a read returns the pins to idle
    @(negedge clk);
    host_valid = 1; host_we = 0; host_addr = 19'h00010; host_mask = 2'b11;
    @(negedge clk);
    host_valid = 0;
    repeat (5) @(negedge clk);
    rst_n = 0;
    @(negedge clk);
    chk_idle("R1");
    rst_n = 1;
    @(negedge clk);
    chk_idle("R1");
    // R7: write directly after read, then read back both lanes
    run_txn(1'b0, 19'h7FFFF, 16'h0, 2'b11, 16'hFFFF);
    run_txn(1'b1, 19'h00020, 16'h9A3C, 2'b11, 16'h0);
    run_txn(1'b0, 19'h00020, 16'h0, 2'b11, 16'h9A3C);
    repeat (4) @(negedge clk);
    chk(err_wr == 0, "R5", err_wr, 0);
    chk(err_cont == 0, "R7", err_cont, 0);
    chk(err_addr == 0, "R10", err_addr, 0);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule